// File: doc/BRIEF.md
# Bus Activity Monitor

This block measures how busy a bus is, per channel. Each channel adds a programmable weight to a period counter for every event pulse it sees. A shared millisecond tick, divided by a programmable global period, marks the end of each sampling period. At that point every running channel latches its count, folds it into an exponential moving average whose window is a power of two, and compares both the raw count and the new average against programmable watermarks.

Crossings of the raw-count watermarks only raise an interrupt once they have lasted a programmable number of back-to-back periods. The upper and lower sides are qualified and enabled separately. Average crossings raise an interrupt in the same period. Status bits are write-one-to-clear, a global status word shows which channels are asserting, and a single interrupt line is the OR of all of them. Software reads the average and retunes the watermarks from its interrupt handler.

Top module: `bus_activity_monitor`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While a channel's enable (control bit 31) and sampling enable (control bit 18) are both set, each cycle with its event input high adds the channel's count weight (offset 0x18) to its period counter. At a period end the counter is taken as that period's sample and restarts from zero.
- R3: The global period register (global offset 0x04) holds P. A period end happens on every (P+1)-th `msTick` pulse. Writing P restarts the tick phase.
- R4: At a period end the average (read at offset 0x1C) becomes avg + ((sample - avg) >>> (K+1)), computed signed, where K is control bits 12:10. Writing offset 0x14 loads the average directly.
- R5: If the sample exceeds the upper watermark (offset 0x04) in N = (control bits 28:26)+1 consecutive periods and control bit 30 is set, status bit 31 is set. The run restarts after firing, after a period that does not qualify, and on a control write.
- R6: If the sample is below the lower watermark (offset 0x08) in N = (control bits 25:23)+1 consecutive periods and control bit 29 is set, status bit 30 is set, with the same restart rules.
- R7: At a period end, a new average above the average-upper watermark (offset 0x0C) with control bit 21 set sets status bit 29. A new average below the average-lower watermark (offset 0x10) with control bit 20 set sets status bit 28.
- R8: Writing the status register (offset 0x20) clears exactly the status bits written as one. Writing all ones clears all of them.
- R9: Global status (global offset 0x00) bit 26-c is high while channel c has any status bit set, and `irq` is the OR of all channels' status bits.
- R10: A channel whose control register is zero does not count events, does not update its average and sets no status bits.
- R11: Address bits 7:6 pick the global block (0) or channel c (c+1). Address bits 5:0 pick the register, and every writable register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register byte address |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| eventIn | input | NUM_CH | Per-channel event pulses |
| msTick | input | 1 | One-cycle millisecond tick |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded assertions check on every cycle that the sampling phase never passes the programmed period, that a run counter never exceeds its programmed length, and that status bits appear only at a period end. They also check that an all-ones status write empties the status, that a stopped channel keeps an empty counter, and that the interrupt rises only right after a period end. Only the directed scenarios can show the arithmetic results: the average values for different window sizes and a negative step, the exact period in which a qualified run fires or is broken, partial status clearing, and the global status bit position for each channel.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam int REG_W = 32;
  localparam int OFF_W = 6;
  localparam int K_W = 3;
  localparam int RUN_W = 3;
  localparam int STAT_W = 4;
  localparam int GSTAT_TOP = 26;

  localparam logic [OFF_W-1:0] OFF_CTRL   = 6'h00;
  localparam logic [OFF_W-1:0] OFF_UPWM   = 6'h04;
  localparam logic [OFF_W-1:0] OFF_LOWM   = 6'h08;
  localparam logic [OFF_W-1:0] OFF_AVGUP  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_AVGLO  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_INIT   = 6'h14;
  localparam logic [OFF_W-1:0] OFF_WEIGHT = 6'h18;
  localparam logic [OFF_W-1:0] OFF_AVG    = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_STAT   = 6'h20;
  localparam logic [OFF_W-1:0] OFF_GSTAT  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_PERIOD = 6'h04;

  localparam int B_K_LO      = 10;
  localparam int B_SAMPLE    = 18;
  localparam int B_AVGLO_EN  = 20;
  localparam int B_AVGUP_EN  = 21;
  localparam int B_LONUM_LO  = 23;
  localparam int B_UPNUM_LO  = 26;
  localparam int B_LORUN_EN  = 29;
  localparam int B_UPRUN_EN  = 30;
  localparam int B_CHAN_EN   = 31;

  typedef struct packed {
    logic wrCtrl;
    logic wrUpWm;
    logic wrLoWm;
    logic wrAvgUp;
    logic wrAvgLo;
    logic wrInit;
    logic wrWeight;
    logic clrStat;
    logic periodEnd;
  } chanStrobe_t;
endpackage

// File: rtl/bam_control.sv
module bam_control
  import bam_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 8,
  parameter int PERIOD_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic                           regWr,
  input  logic [REG_W-1:0]               regWdata,
  input  logic                           msTick,
  input  logic [NUM_CH-1:0][REG_W-1:0]   chanRdata,
  input  logic [NUM_CH-1:0]              chanIntr,
  output chanStrobe_t [NUM_CH-1:0]       strb,
  output logic [OFF_W-1:0]               regOff,
  output logic [REG_W-1:0]               regRdata,
  output logic                           periodEnd
);
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [BLK_W-1:0]    blk;
  logic [PERIOD_W-1:0] periodReg;
  logic [PERIOD_W-1:0] tickCnt;
  logic [REG_W-1:0]    gstat;
  logic                periodWr;

  assign blk      = regAddr[ADDR_W-1:OFF_W];
  assign regOff   = regAddr[OFF_W-1:0];
  assign periodWr = regWr && (blk == '0) && (regOff == OFF_PERIOD);
  assign periodEnd = msTick && (tickCnt == periodReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodReg <= '0;
      tickCnt   <= '0;
    end else begin
      if (periodWr) begin
        periodReg <= regWdata[PERIOD_W-1:0];
        tickCnt   <= '0;
      end else if (msTick) begin
        tickCnt <= periodEnd ? '0 : tickCnt + 1'b1;
      end
    end
  end

  always_comb begin
    gstat = '0;
    for (int c = 0; c < NUM_CH; c++) gstat[GSTAT_TOP-c] = chanIntr[c];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strb
    logic hit;
    assign hit = regWr && (blk == BLK_W'(c + 1));
    assign strb[c].wrCtrl    = hit && (regOff == OFF_CTRL);
    assign strb[c].wrUpWm    = hit && (regOff == OFF_UPWM);
    assign strb[c].wrLoWm    = hit && (regOff == OFF_LOWM);
    assign strb[c].wrAvgUp   = hit && (regOff == OFF_AVGUP);
    assign strb[c].wrAvgLo   = hit && (regOff == OFF_AVGLO);
    assign strb[c].wrInit    = hit && (regOff == OFF_INIT);
    assign strb[c].wrWeight  = hit && (regOff == OFF_WEIGHT);
    assign strb[c].clrStat   = hit && (regOff == OFF_STAT);
    assign strb[c].periodEnd = periodEnd;
  end

  always_comb begin
    regRdata = '0;
    if (blk == '0) begin
      if (regOff == OFF_GSTAT)       regRdata = gstat;
      else if (regOff == OFF_PERIOD) regRdata = REG_W'(periodReg);
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (blk == BLK_W'(c + 1)) regRdata = chanRdata[c];
    end
  end

  // Sampling phase never runs past the programmed period
  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= periodReg);
endmodule

// File: rtl/bam_channel.sv
module bam_channel
  import bam_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strb,
  input  logic [REG_W-1:0]  wdata,
  input  logic [OFF_W-1:0]  rdOff,
  input  logic              eventIn,
  output logic [REG_W-1:0]  rdata,
  output logic              intrAny
);
  logic [REG_W-1:0] ctrlReg, upWm, loWm, avgUpWm, avgLoWm, weight;
  logic [REG_W-1:0] accum, avgReg, newAvg, sumNext;
  logic [STAT_W-1:0] statReg, setBits, clrMask;
  logic [RUN_W-1:0] aboveRun, belowRun, aboveNum, belowNum;
  logic [K_W-1:0] kVal;
  logic signed [REG_W:0] diff, step;
  logic chanOn, active, sampleNow, aboveHit, belowHit, fireAbove, fireBelow;
  logic [REG_W:0] sumWide;

  assign chanOn   = ctrlReg[B_CHAN_EN];
  assign active   = chanOn && ctrlReg[B_SAMPLE];
  assign kVal     = ctrlReg[B_K_LO +: K_W];
  assign aboveNum = ctrlReg[B_UPNUM_LO +: RUN_W];
  assign belowNum = ctrlReg[B_LONUM_LO +: RUN_W];
  assign sampleNow = active && strb.periodEnd;

  // Saturating accumulation of weighted events
  assign sumWide = {1'b0, accum} + {1'b0, weight};
  assign sumNext = sumWide[REG_W] ? '1 : sumWide[REG_W-1:0];

  // Exponential average step, signed
  assign diff   = $signed({1'b0, accum}) - $signed({1'b0, avgReg});
  assign step   = diff >>> ({1'b0, kVal} + 4'd1);
  assign newAvg = avgReg + step[REG_W-1:0];

  assign aboveHit  = accum > upWm;
  assign belowHit  = accum < loWm;
  assign fireAbove = sampleNow && aboveHit && (aboveRun == aboveNum) && ctrlReg[B_UPRUN_EN];
  assign fireBelow = sampleNow && belowHit && (belowRun == belowNum) && ctrlReg[B_LORUN_EN];

  always_comb begin
    setBits = '0;
    setBits[3] = fireAbove;
    setBits[2] = fireBelow;
    setBits[1] = sampleNow && ctrlReg[B_AVGUP_EN] && (newAvg > avgUpWm);
    setBits[0] = sampleNow && ctrlReg[B_AVGLO_EN] && (newAvg < avgLoWm);
    clrMask = strb.clrStat ? wdata[REG_W-1 -: STAT_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0; upWm <= '0; loWm <= '0; avgUpWm <= '0; avgLoWm <= '0;
      weight <= '0;
    end else begin
      if (strb.wrCtrl)   ctrlReg <= wdata;
      if (strb.wrUpWm)   upWm    <= wdata;
      if (strb.wrLoWm)   loWm    <= wdata;
      if (strb.wrAvgUp)  avgUpWm <= wdata;
      if (strb.wrAvgLo)  avgLoWm <= wdata;
      if (strb.wrWeight) weight  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accum <= '0;
    end else if (!active) begin
      accum <= '0;
    end else if (strb.periodEnd) begin
      accum <= eventIn ? weight : '0;
    end else if (eventIn) begin
      accum <= sumNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            avgReg <= '0;
    else if (strb.wrInit) avgReg <= wdata;
    else if (sampleNow)   avgReg <= newAvg;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active || strb.wrCtrl) begin
      aboveRun <= '0;
      belowRun <= '0;
    end else if (strb.periodEnd) begin
      aboveRun <= (!aboveHit || aboveRun == aboveNum) ? '0 : aboveRun + 1'b1;
      belowRun <= (!belowHit || belowRun == belowNum) ? '0 : belowRun + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statReg <= '0;
    else       statReg <= (statReg & ~clrMask) | setBits;
  end

  assign intrAny = |statReg;

  always_comb begin
    case (rdOff)
      OFF_CTRL:   rdata = ctrlReg;
      OFF_UPWM:   rdata = upWm;
      OFF_LOWM:   rdata = loWm;
      OFF_AVGUP:  rdata = avgUpWm;
      OFF_AVGLO:  rdata = avgLoWm;
      OFF_INIT:   rdata = avgReg;
      OFF_WEIGHT: rdata = weight;
      OFF_AVG:    rdata = avgReg;
      OFF_STAT:   rdata = {statReg, {(REG_W-STAT_W){1'b0}}};
      default:    rdata = '0;
    endcase
  end

  assert_run_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    aboveRun <= aboveNum);

  assert_run_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    belowRun <= belowNum);

  assert_stat_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.periodEnd |=> ((statReg & ~$past(statReg)) == '0));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStat && (wdata == '1) && !strb.periodEnd) |=> (statReg == '0));

  assert_stopped_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !chanOn |=> (accum == '0));
endmodule

// File: rtl/bus_activity_monitor.sv
module bus_activity_monitor
  import bam_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 8,
  parameter int PERIOD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [NUM_CH-1:0] eventIn,
  input  logic              msTick,
  output logic              irq
);
  chanStrobe_t [NUM_CH-1:0]     strb;
  logic [NUM_CH-1:0][REG_W-1:0] chanRdata;
  logic [NUM_CH-1:0]            chanIntr;
  logic [OFF_W-1:0]             regOff;
  logic                         periodEnd;

  bam_control #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .msTick(msTick), .chanRdata(chanRdata), .chanIntr(chanIntr), .strb(strb),
    .regOff(regOff), .regRdata(regRdata), .periodEnd(periodEnd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    bam_channel u_chan (
      .clk(clk), .rstN(rstN), .strb(strb[c]), .wdata(regWdata), .rdOff(regOff),
      .eventIn(eventIn[c]), .rdata(chanRdata[c]), .intrAny(chanIntr[c])
    );
  end

  assign irq = |chanIntr;

  // Interrupt only appears right after a period end
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(periodEnd));
endmodule

// File: tb/bus_activity_monitor_tb.sv
module bus_activity_monitor_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  regAddr;
  logic        regWr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic [1:0]  eventIn;
  logic        msTick;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_activity_monitor u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .eventIn(eventIn), .msTick(msTick), .irq(irq)
  );

  function automatic logic [7:0] ca(input int ch, input logic [7:0] off);
    return 8'((ch + 1) << 6) | off;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic pulseEvents(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); eventIn[ch] = 1'b1;
      @(negedge clk); eventIn[ch] = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); msTick = 1'b1;
      @(negedge clk); msTick = 1'b0;
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(ca(0, 8'h00), d); check("R1", "ctrl after reset", d, 0);
    rd(ca(0, 8'h20), d); check("R1", "status after reset", d, 0);
    rd(8'h00, d);        check("R1", "global status after reset", d, 0);
    check("R1", "irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic testReadback();
    logic [31:0] d;
    wr(ca(0, 8'h04), 32'h0000_1234); rd(ca(0, 8'h04), d); check("R11", "upper wm", d, 32'h1234);
    wr(ca(0, 8'h10), 32'h0000_00AB); rd(ca(0, 8'h10), d); check("R11", "avg lower wm", d, 32'hAB);
    wr(ca(1, 8'h18), 32'h0000_0055); rd(ca(1, 8'h18), d); check("R11", "ch1 weight", d, 32'h55);
  endtask

  task automatic testAverage();
    logic [31:0] d;
    wr(ca(0, 8'h18), 10); wr(ca(0, 8'h14), 0); wr(ca(0, 8'h00), 32'h8004_0000);
    pulseEvents(0, 10); ticks(1);
    rd(ca(0, 8'h1C), d); check("R4", "avg K=0 first", d, 50);
    pulseEvents(0, 10); ticks(1);
    rd(ca(0, 8'h1C), d); check("R4", "avg K=0 second", d, 75);
    wr(ca(0, 8'h18), 7); wr(ca(0, 8'h14), 0);
    pulseEvents(0, 3); ticks(1);
    rd(ca(0, 8'h1C), d); check("R2", "weight 7 x3 averaged", d, 10);
    wr(ca(0, 8'h00), 32'h8004_0800); wr(ca(0, 8'h14), 800);
    ticks(1);
    rd(ca(0, 8'h1C), d); check("R4", "avg K=2 negative step", d, 700);
  endtask

  task automatic testAboveRun();
    logic [31:0] d;
    wr(ca(0, 8'h18), 10); wr(ca(0, 8'h04), 50); wr(ca(0, 8'h08), 0);
    wr(ca(0, 8'h00), 32'hC404_0000); wr(ca(0, 8'h20), 32'hFFFF_FFFF);
    pulseEvents(0, 10); ticks(1);
    rd(ca(0, 8'h20), d); check("R5", "no fire after one period", d, 0);
    pulseEvents(0, 10); ticks(1);
    rd(ca(0, 8'h20), d); check("R5", "fire after two periods", d, 32'h8000_0000);
    check("R9", "irq on fire", {31'b0, irq}, 1);
    wr(ca(0, 8'h20), 32'hFFFF_FFFF);
    pulseEvents(0, 10); ticks(1);
    ticks(1);
    pulseEvents(0, 10); ticks(1);
    rd(ca(0, 8'h20), d); check("R5", "broken run no fire", d, 0);
    pulseEvents(0, 10); ticks(1);
    rd(ca(0, 8'h20), d); check("R5", "fire after rebuilt run", d, 32'h8000_0000);
  endtask

  task automatic testClear();
    logic [31:0] d;
    wr(ca(0, 8'h20), 32'h7FFF_FFFF);
    rd(ca(0, 8'h20), d); check("R8", "partial clear keeps bit31", d, 32'h8000_0000);
    wr(ca(0, 8'h20), 32'hFFFF_FFFF);
    rd(ca(0, 8'h20), d); check("R8", "all ones clears", d, 0);
    check("R8", "irq after clear", {31'b0, irq}, 0);
  endtask

  task automatic testBelowRun();
    logic [31:0] d;
    wr(ca(0, 8'h04), 32'hFFFF_FFFF); wr(ca(0, 8'h08), 30);
    wr(ca(0, 8'h00), 32'hA104_0000);
    ticks(2);
    rd(ca(0, 8'h20), d); check("R6", "no fire after two periods", d, 0);
    ticks(1);
    rd(ca(0, 8'h20), d); check("R6", "fire after three periods", d, 32'h4000_0000);
    wr(ca(0, 8'h20), 32'hFFFF_FFFF);
  endtask

  task automatic testAvgWm();
    logic [31:0] d;
    wr(ca(0, 8'h0C), 40); wr(ca(0, 8'h10), 5); wr(ca(0, 8'h14), 0);
    wr(ca(0, 8'h18), 10); wr(ca(0, 8'h00), 32'h8034_0000);
    pulseEvents(0, 10); ticks(1);
    rd(ca(0, 8'h20), d); check("R7", "avg above sets bit29", d, 32'h2000_0000);
    wr(ca(0, 8'h20), 32'hFFFF_FFFF); wr(ca(0, 8'h14), 10);
    ticks(1);
    rd(ca(0, 8'h20), d); check("R7", "avg equal to low wm no set", d, 0);
    ticks(1);
    rd(ca(0, 8'h1C), d); check("R4", "avg floor of negative step", d, 2);
    rd(ca(0, 8'h20), d); check("R7", "avg below sets bit28", d, 32'h1000_0000);
    wr(ca(0, 8'h20), 32'hFFFF_FFFF);
  endtask

  task automatic testStop();
    logic [31:0] d;
    wr(ca(0, 8'h00), 0); wr(ca(0, 8'h18), 10); wr(ca(0, 8'h14), 123);
    pulseEvents(0, 5); ticks(2);
    rd(ca(0, 8'h1C), d); check("R10", "avg frozen while stopped", d, 123);
    rd(ca(0, 8'h20), d); check("R10", "no status while stopped", d, 0);
    wr(ca(0, 8'h00), 32'h8004_0000);
    ticks(1);
    rd(ca(0, 8'h1C), d); check("R10", "stopped events not counted", d, 61);
  endtask

  task automatic testGlobal();
    logic [31:0] d;
    wr(ca(1, 8'h18), 1); wr(ca(1, 8'h04), 0); wr(ca(1, 8'h00), 32'hC004_0000);
    pulseEvents(1, 1); ticks(1);
    rd(8'h00, d); check("R9", "global bit for ch1", d, 32'h0200_0000);
    check("R9", "irq from ch1", {31'b0, irq}, 1);
    wr(ca(0, 8'h00), 32'hC004_0000); wr(ca(0, 8'h04), 0);
    pulseEvents(0, 1); ticks(1);
    rd(8'h00, d); check("R9", "global bits both", d, 32'h0600_0000);
    wr(ca(0, 8'h00), 0); wr(ca(1, 8'h00), 0);
    wr(ca(0, 8'h20), 32'hFFFF_FFFF); wr(ca(1, 8'h20), 32'hFFFF_FFFF);
    check("R9", "irq low after clears", {31'b0, irq}, 0);
  endtask

  task automatic testPeriod();
    logic [31:0] d;
    wr(8'h04, 3); rd(8'h04, d); check("R3", "period readback", d, 3);
    wr(ca(0, 8'h18), 10); wr(ca(0, 8'h14), 0); wr(ca(0, 8'h00), 32'h8004_0000);
    wr(8'h04, 3);
    pulseEvents(0, 4); ticks(3);
    rd(ca(0, 8'h1C), d); check("R3", "no update before fourth tick", d, 0);
    ticks(1);
    rd(ca(0, 8'h1C), d); check("R3", "update on fourth tick", d, 20);
  endtask

  initial begin
    rstN = 1'b0; regAddr = '0; regWr = 1'b0; regWdata = '0; eventIn = '0; msTick = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadback();
    testAverage();
    testAboveRun();
    testClear();
    testBelowRun();
    testAvgWm();
    testStop();
    testGlobal();
    testPeriod();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule